// File: doc/BRIEF.md
# Memory Protection Region Checker

This block holds up to sixteen programmable protection regions and checks every bus access against them. Software programs it through a small register write port. That port has four registers: a global control register, a region-select register, a base-address register for the selected region and an attribute/size register for the selected region. Each access presents an address and three flags: privileged, write and instruction fetch. One clock later the block answers with an allow/fault decision, whether a region matched, which region matched, and the memory-type attribute bits stored with that region.

A region covers a power-of-two range of bytes that is aligned to its own size. It is split into eight equal sub-regions, and each sub-region can be switched off. A 3-bit code sets the read and write rights for privileged and unprivileged accesses. A separate execute-never bit blocks instruction fetches. When regions overlap, the highest-numbered matching region decides the result. While the global enable is clear, every access is allowed.

Top module: `prot_region_check`

## Requirements
- R1: After synchronous reset, rsp_valid and rsp_allow are 0, the global enable is clear, the region-select register is 0, and every region is disabled.
- R2: A write selects its register with cfg_sel: 0 = control (bit 0 is the global enable), 1 = region select (bits 3:0), 2 = base address (bits 31:5 hold the base, bit 4 is the valid flag, bits 3:0 are a region number), 3 = attribute/size word of the selected region. A base write with bit 4 set first loads bits 3:0 into the region-select register, then stores the base in that region. With bit 4 clear, the base goes to the currently selected region.
- R3: The attribute/size word packs these fields: bit 0 enable, bits 5:1 size code N, bits 13:6 sub-region disable, bits 16:14 permission, bit 17 execute-never, bits 20:18 type extension, bit 21 shareable, bit 22 cacheable, bit 23 bufferable. An enabled region with N >= 4 covers 2^(N+1) bytes starting at its base. Base bits below the region size are ignored. N = 31 covers the whole 4 GB space. A region with N < 4 never matches.
- R4: Sub-region k is the k-th eighth of a region, counted from its low end. When disable bit k is 1, addresses in sub-region k do not match that region.
- R5: The permission codes are: 0 = no access; 1 = privileged read/write only; 2 = privileged read/write, unprivileged read only; 3 = read/write for all; 5 = privileged read only; 6 = read only for all. Codes 4 and 7 fault every access.
- R6: An instruction fetch is checked as a read, and acc_write is ignored while acc_fetch is set. A fetch that hits a region with execute-never set faults.
- R7: When several enabled regions match an address, the highest-numbered one supplies the decision, the region number and the attributes.
- R8: While the global enable is clear, every access is allowed, and rsp_hit and all attribute outputs are 0.
- R9: While the global enable is set, an access that matches no region faults, with rsp_hit, rsp_region and the attributes all 0.
- R10: On a hit, rsp_region, rsp_tex, rsp_shareable, rsp_cacheable and rsp_bufferable carry the deciding region's number and stored field values unchanged.
- R11: An access presented at a clock edge with acc_valid high is answered at the next edge, with rsp_valid high for exactly one cycle. A configuration write takes effect for accesses presented at later edges.
- R12: Writing zero to a region's attribute/size word disables that region, so that region no longer matches anything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select for the write |
| cfg_wdata | input | 32 | Register write data |
| acc_valid | input | 1 | Access present |
| acc_addr | input | 32 | Access byte address |
| acc_priv | input | 1 | 1 = privileged access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_fetch | input | 1 | 1 = instruction fetch |
| rsp_valid | output | 1 | Decision valid |
| rsp_allow | output | 1 | 1 = allowed, 0 = fault |
| rsp_hit | output | 1 | A region matched |
| rsp_region | output | 4 | Number of the deciding region |
| rsp_tex | output | 3 | Type extension bits of that region |
| rsp_shareable | output | 1 | Shareable bit of that region |
| rsp_cacheable | output | 1 | Cacheable bit of that region |
| rsp_bufferable | output | 1 | Bufferable bit of that region |

## Verification
The bench places a small region inside a larger one and probes addresses on both sides of the inner boundary. A design that ranked regions the wrong way would report the outer region's number and attributes. It writes a base with stray low bits, which a design that compared those bits would turn into a miss. It disables a single sub-region and probes that eighth and its neighbour, which exposes an off-by-one in the sub-region index. It sweeps all eight permission codes across privilege, write and fetch, which catches a swapped row or a reserved code that grants access. Finally it uses a base write with the valid flag set, followed by an attribute write: a design that ignored the embedded region number would program the wrong region.

// File: rtl/prot_pkg.sv
package prot_pkg;
  localparam int ADDR_W        = 32;
  localparam int BASE_LSB      = 5;
  localparam int ATTR_W        = 24;
  localparam int MIN_SIZE_CODE = 4;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_RNUM = 2'd1;
  localparam logic [1:0] SEL_BASE = 2'd2;
  localparam logic [1:0] SEL_ATTR = 2'd3;

  localparam int BASE_VALID_BIT = 4;

  typedef struct packed {
    logic                       buf_en;
    logic                       cache_en;
    logic                       share;
    logic [2:0]                 tex;
    logic                       xn;
    logic [2:0]                 perm;
    logic [7:0]                 srd;
    logic [4:0]                 size;
    logic                       en;
  } attr_t;

  typedef struct packed {
    logic [ADDR_W-1:BASE_LSB]   base;
    attr_t                      attr;
  } region_cfg_t;

  // read/write right for one access class
  function automatic logic perm_grant(input logic [2:0] code,
                                      input logic priv,
                                      input logic wr);
    logic ok;
    case (code)
      3'd1:    ok = priv;
      3'd2:    ok = priv | ~wr;
      3'd3:    ok = 1'b1;
      3'd5:    ok = priv & ~wr;
      3'd6:    ok = ~wr;
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction
endpackage

// File: rtl/prot_region_match.sv
module prot_region_match
  import prot_pkg::*;
(
  input  region_cfg_t       cfg,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  logic [ADDR_W:0]   span;
  logic [ADDR_W-1:0] keep;
  logic [ADDR_W-1:0] base_full;
  logic [ADDR_W-1:0] shifted;
  logic [2:0]        sub;
  logic              in_range;

  always_comb begin
    span      = (ADDR_W+1)'(1) << ({1'b0, cfg.attr.size} + 6'd1);
    keep      = ~(span[ADDR_W-1:0] - ADDR_W'(1));
    base_full = {cfg.base, {BASE_LSB{1'b0}}};
    shifted   = addr >> (cfg.attr.size - 5'd2);
    sub       = shifted[2:0];
    in_range  = ((addr ^ base_full) & keep) == '0;
    hit       = cfg.attr.en
              && (int'(cfg.attr.size) >= MIN_SIZE_CODE)
              && in_range
              && !cfg.attr.srd[sub];
  end
endmodule

// File: rtl/prot_regfile.sv
module prot_regfile
  import prot_pkg::*;
#(
  parameter int NUM_REGIONS = 16,
  localparam int RIDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [31:0]       wdata,
  output logic              ctrl_en,
  output region_cfg_t       cfg [NUM_REGIONS]
);
  logic [RIDX_W-1:0]          rnum_q;
  logic [ADDR_W-1:BASE_LSB]   base_q [NUM_REGIONS];
  attr_t                      attr_q [NUM_REGIONS];
  logic [RIDX_W-1:0]          base_idx;
  logic                       base_sel_ok;
  logic                       attr_sel_ok;

  always_comb begin
    base_idx    = wdata[BASE_VALID_BIT] ? wdata[RIDX_W-1:0] : rnum_q;
    base_sel_ok = int'(base_idx) < NUM_REGIONS;
    attr_sel_ok = int'(rnum_q) < NUM_REGIONS;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en <= 1'b0;
      rnum_q  <= '0;
    end else if (we) begin
      if (sel == SEL_CTRL) ctrl_en <= wdata[0];
      if (sel == SEL_RNUM) rnum_q  <= wdata[RIDX_W-1:0];
      if (sel == SEL_BASE && wdata[BASE_VALID_BIT]) rnum_q <= wdata[RIDX_W-1:0];
    end
  end

  // per-region storage, one write port each
  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_store
    always_ff @(posedge clk) begin
      if (rst) begin
        base_q[g] <= '0;
        attr_q[g] <= '0;
      end else if (we) begin
        if (sel == SEL_BASE && base_sel_ok && base_idx == RIDX_W'(g))
          base_q[g] <= wdata[ADDR_W-1:BASE_LSB];
        if (sel == SEL_ATTR && attr_sel_ok && rnum_q == RIDX_W'(g))
          attr_q[g] <= attr_t'(wdata[ATTR_W-1:0]);
      end
    end
    assign cfg[g] = '{base: base_q[g], attr: attr_q[g]};
  end
endmodule

// File: rtl/prot_decide.sv
module prot_decide
  import prot_pkg::*;
#(
  parameter int NUM_REGIONS = 16,
  localparam int RIDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  region_cfg_t       cfg [NUM_REGIONS],
  input  logic [NUM_REGIONS-1:0] hits,
  input  logic              ctrl_en,
  input  logic              priv,
  input  logic              wr,
  input  logic              fetch,
  output logic              allow,
  output logic              any_hit,
  output logic [RIDX_W-1:0] win,
  output logic [2:0]        tex,
  output logic              share,
  output logic              cache_en,
  output logic              buf_en
);
  attr_t chosen;
  logic  wr_eff;
  logic  grant;

  always_comb begin
    any_hit = 1'b0;
    win     = '0;
    // ascending scan: the last hit, i.e. the highest number, wins
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (hits[i]) begin
        any_hit = 1'b1;
        win     = RIDX_W'(i);
      end
    end
    chosen = cfg[win].attr;
    wr_eff = wr & ~fetch;
    grant  = perm_grant(chosen.perm, priv, wr_eff) & ~(fetch & chosen.xn);

    if (!ctrl_en) begin
      allow    = 1'b1;
      any_hit  = 1'b0;
      win      = '0;
      tex      = '0;
      share    = 1'b0;
      cache_en = 1'b0;
      buf_en   = 1'b0;
    end else if (!any_hit) begin
      allow    = 1'b0;
      tex      = '0;
      share    = 1'b0;
      cache_en = 1'b0;
      buf_en   = 1'b0;
    end else begin
      allow    = grant;
      tex      = chosen.tex;
      share    = chosen.share;
      cache_en = chosen.cache_en;
      buf_en   = chosen.buf_en;
    end
  end
endmodule

// File: rtl/prot_region_check.sv
module prot_region_check
  import prot_pkg::*;
#(
  parameter int NUM_REGIONS = 16,
  localparam int RIDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic              acc_valid,
  input  logic [31:0]       acc_addr,
  input  logic              acc_priv,
  input  logic              acc_write,
  input  logic              acc_fetch,
  output logic              rsp_valid,
  output logic              rsp_allow,
  output logic              rsp_hit,
  output logic [RIDX_W-1:0] rsp_region,
  output logic [2:0]        rsp_tex,
  output logic              rsp_shareable,
  output logic              rsp_cacheable,
  output logic              rsp_bufferable
);
  logic                   ctrl_en;
  region_cfg_t            cfg [NUM_REGIONS];
  logic [NUM_REGIONS-1:0] hits;
  logic                   d_allow, d_hit, d_share, d_cache, d_buf;
  logic [RIDX_W-1:0]      d_win;
  logic [2:0]             d_tex;

  prot_regfile #(.NUM_REGIONS(NUM_REGIONS)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .ctrl_en(ctrl_en), .cfg(cfg)
  );

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_match
    prot_region_match u_match (
      .cfg(cfg[g]), .addr(acc_addr), .hit(hits[g])
    );
  end

  prot_decide #(.NUM_REGIONS(NUM_REGIONS)) u_decide (
    .cfg(cfg), .hits(hits), .ctrl_en(ctrl_en),
    .priv(acc_priv), .wr(acc_write), .fetch(acc_fetch),
    .allow(d_allow), .any_hit(d_hit), .win(d_win), .tex(d_tex),
    .share(d_share), .cache_en(d_cache), .buf_en(d_buf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid      <= 1'b0;
      rsp_allow      <= 1'b0;
      rsp_hit        <= 1'b0;
      rsp_region     <= '0;
      rsp_tex        <= '0;
      rsp_shareable  <= 1'b0;
      rsp_cacheable  <= 1'b0;
      rsp_bufferable <= 1'b0;
    end else begin
      rsp_valid      <= acc_valid;
      rsp_allow      <= acc_valid & d_allow;
      rsp_hit        <= acc_valid & d_hit;
      rsp_region     <= acc_valid ? d_win : '0;
      rsp_tex        <= acc_valid ? d_tex : '0;
      rsp_shareable  <= acc_valid & d_share;
      rsp_cacheable  <= acc_valid & d_cache;
      rsp_bufferable <= acc_valid & d_buf;
    end
  end
endmodule

// File: rtl/prot_region_check_sva.sv
module prot_region_check_sva #(
  parameter int RIDX_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_valid,
  input logic              ctrl_en,
  input logic              rsp_valid,
  input logic              rsp_allow,
  input logic              rsp_hit,
  input logic [RIDX_W-1:0] rsp_region,
  input logic [2:0]        rsp_tex,
  input logic              rsp_shareable,
  input logic              rsp_cacheable,
  input logic              rsp_bufferable
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!rsp_valid && !rsp_allow));

  assert_resp_follows_R11: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> rsp_valid);

  assert_idle_no_resp_R11: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !rsp_valid);

  assert_off_allows_R8: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !ctrl_en) |=> (rsp_allow && !rsp_hit && rsp_tex == 3'd0));

  assert_miss_faults_R9: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && ctrl_en) ##1 !rsp_hit |-> (!rsp_allow && rsp_region == '0));

  assert_miss_no_attr_R10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (!rsp_shareable && !rsp_cacheable && !rsp_bufferable));
endmodule

bind prot_region_check prot_region_check_sva #(.RIDX_W(RIDX_W)) u_sva (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .ctrl_en(ctrl_en),
  .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_hit(rsp_hit),
  .rsp_region(rsp_region), .rsp_tex(rsp_tex), .rsp_shareable(rsp_shareable),
  .rsp_cacheable(rsp_cacheable), .rsp_bufferable(rsp_bufferable)
);

// File: tb/prot_region_check_test.sv
module prot_region_check_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        acc_priv = 1'b0, acc_write = 1'b0, acc_fetch = 1'b0;
  logic        rsp_valid, rsp_allow, rsp_hit;
  logic [3:0]  rsp_region;
  logic [2:0]  rsp_tex;
  logic        rsp_shareable, rsp_cacheable, rsp_bufferable;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // bench mirror of the programmed state
  logic        m_ctrl;
  logic [3:0]  m_rnum;
  logic [26:0] m_base [16];
  logic [23:0] m_attr [16];

  always #2 clk = ~clk;

  prot_region_check uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_priv(acc_priv),
    .acc_write(acc_write), .acc_fetch(acc_fetch),
    .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_hit(rsp_hit),
    .rsp_region(rsp_region), .rsp_tex(rsp_tex), .rsp_shareable(rsp_shareable),
    .rsp_cacheable(rsp_cacheable), .rsp_bufferable(rsp_bufferable)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL R11 watchdog: actual cycles %0d expected below %0d", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic [23:0] mk_attr(input logic en, input logic [4:0] size,
      input logic [7:0] srd, input logic [2:0] perm, input logic xn,
      input logic [2:0] tex, input logic s, input logic c, input logic b);
    return {b, c, s, tex, xn, perm, srd, size, en};
  endfunction

  function automatic logic grant(input logic [2:0] p, input logic pr, input logic w);
    case (p)
      3'd1: return pr;
      3'd2: return pr | ~w;
      3'd3: return 1'b1;
      3'd5: return pr & ~w;
      3'd6: return ~w;
      default: return 1'b0;
    endcase
  endfunction

  // {allow, hit, region[3:0], tex[2:0], s, c, b}
  function automatic logic [11:0] model(input logic [31:0] addr, input logic pr,
                                        input logic w, input logic f);
    logic [63:0] sz, lo, a64;
    logic [23:0] at;
    logic        found, ok;
    int          win, sub;
    if (!m_ctrl) return {1'b1, 11'b0};
    found = 1'b0; win = 0;
    a64 = {32'b0, addr};
    for (int i = 0; i < 16; i++) begin
      at = m_attr[i];
      if (at[0] && at[5:1] >= 5'd4) begin
        sz = 64'd1 << (at[5:1] + 1);
        lo = {32'b0, m_base[i], 5'b0} & ~(sz - 64'd1);
        if (a64 >= lo && a64 < lo + sz) begin
          sub = int'((a64 - lo) / (sz >> 3));
          if (!at[6 + sub]) begin found = 1'b1; win = i; end
        end
      end
    end
    if (!found) return 12'b0;
    at = m_attr[win];
    ok = grant(at[16:14], pr, w & ~f) & ~(f & at[17]);
    return {ok, 1'b1, 4'(win), at[20:18], at[21], at[22], at[23]};
  endfunction

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (sel)
      2'd0: m_ctrl = d[0];
      2'd1: m_rnum = d[3:0];
      2'd2: begin
        if (d[4]) m_rnum = d[3:0];
        m_base[m_rnum] = d[31:5];
      end
      default: m_attr[m_rnum] = d[23:0];
    endcase
  endtask

  task automatic probe(input logic [31:0] a, input logic pr, input logic w,
                       input logic f, input string tag);
    logic [11:0] exp, act;
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_priv = pr; acc_write = w; acc_fetch = f;
    exp = model(a, pr, w, f);
    @(negedge clk);
    acc_valid = 1'b0;
    act = {rsp_allow, rsp_hit, rsp_region, rsp_tex, rsp_shareable, rsp_cacheable, rsp_bufferable};
    checks++;
    if (!rsp_valid || act !== exp) begin
      fails++;
      $display("FAIL %s addr=%h priv=%0b wr=%0b fetch=%0b: actual valid=%0b %h expected valid=1 %h",
               tag, a, pr, w, f, rsp_valid, act, exp);
    end
  endtask

  initial begin
    m_ctrl = 1'b0; m_rnum = '0;
    for (int i = 0; i < 16; i++) begin m_base[i] = '0; m_attr[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: quiet after reset
    checks++;
    if (rsp_valid !== 1'b0 || rsp_allow !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: actual valid=%0b allow=%0b expected 0 0", rsp_valid, rsp_allow);
    end
    probe(32'h1234_5678, 1'b0, 1'b1, 1'b0, "R8 disabled allows");
    // R11: no response one cycle later
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      fails++;
      $display("FAIL R11 single pulse: actual %0b expected 0", rsp_valid);
    end

    cfg_write(2'd0, 32'h1);
    probe(32'h2000_0800, 1'b1, 1'b0, 1'b0, "R9 enabled no region");

    // region 2: 4 KB at 0x2000_0000, full access, tex 5 s c b
    cfg_write(2'd1, 32'd2);
    cfg_write(2'd2, 32'h2000_0000);
    cfg_write(2'd3, {8'd0, mk_attr(1, 5'd11, 8'h00, 3'd3, 0, 3'd5, 1, 0, 1)});
    probe(32'h2000_0800, 1'b0, 1'b0, 1'b0, "R10 attrs of hit");
    probe(32'h2000_1000, 1'b0, 1'b0, 1'b0, "R3 just past end");
    probe(32'h1FFF_FFFC, 1'b0, 1'b0, 1'b0, "R3 just below base");
    cfg_write(2'd2, 32'h2000_0FE0);
    probe(32'h2000_0004, 1'b0, 1'b1, 1'b0, "R3 low base bits ignored");

    // R4: disable sub-region 3 (0x600..0x7FF)
    cfg_write(2'd3, {8'd0, mk_attr(1, 5'd11, 8'h08, 3'd3, 0, 3'd5, 1, 0, 1)});
    probe(32'h2000_0600, 1'b0, 1'b0, 1'b0, "R4 disabled sub-region");
    probe(32'h2000_05FC, 1'b0, 1'b0, 1'b0, "R4 neighbour sub-region");

    // R2: base write with valid flag picks region 7, attr then lands there
    cfg_write(2'd2, 32'h2000_0000 | 32'h10 | 32'd7);
    cfg_write(2'd3, {8'd0, mk_attr(1, 5'd9, 8'h00, 3'd6, 1, 3'd2, 0, 1, 0)});
    probe(32'h2000_0100, 1'b1, 1'b0, 1'b0, "R2 valid base selects region");
    probe(32'h2000_0100, 1'b1, 1'b0, 1'b1, "R6 execute-never fetch");
    probe(32'h2000_0100, 1'b1, 1'b1, 1'b0, "R7 upper region read-only write");
    probe(32'h2000_0900, 1'b1, 1'b1, 1'b0, "R7 outside upper region");

    // R5 sweep on region 7, plus fetch with xn clear
    for (int p = 0; p < 8; p++) begin
      cfg_write(2'd3, {8'd0, mk_attr(1, 5'd9, 8'h00, 3'(p), 0, 3'd1, 0, 0, 1)});
      for (int k = 0; k < 8; k++)
        probe(32'h2000_0040, k[0], k[1], k[2], "R5 permission sweep");
    end

    // R12: clear region 7
    cfg_write(2'd1, 32'd7);
    cfg_write(2'd3, 32'h0);
    probe(32'h2000_0100, 1'b0, 1'b0, 1'b0, "R12 cleared region");

    // R3: whole space in region 15, and undersized code
    cfg_write(2'd1, 32'd15);
    cfg_write(2'd3, {8'd0, mk_attr(1, 5'd31, 8'h00, 3'd2, 0, 3'd7, 0, 0, 0)});
    probe(32'hFFFF_FFF0, 1'b0, 1'b1, 1'b0, "R3 4 GB region");
    probe(32'h0000_0000, 1'b0, 1'b0, 1'b0, "R3 4 GB region low end");
    cfg_write(2'd3, {8'd0, mk_attr(1, 5'd3, 8'h00, 3'd3, 0, 3'd0, 0, 0, 0)});
    probe(32'h0000_0000, 1'b0, 1'b0, 1'b0, "R3 undersized code");

    // random configurations and accesses, fixed seed
    void'($urandom(32'd7321));
    for (int it = 0; it < 250; it++) begin
      logic [31:0] b;
      logic [4:0]  sz;
      b  = ($urandom & 32'h0003_FFE0) | (($urandom % 2) << 28);
      sz = ($urandom % 10 == 0) ? 5'd31 : 5'(4 + $urandom % 14);
      if ($urandom % 2) cfg_write(2'd2, b | 32'h10 | ($urandom % 16));
      else begin
        cfg_write(2'd1, $urandom % 16);
        cfg_write(2'd2, b);
      end
      cfg_write(2'd3, {8'd0, mk_attr(($urandom % 5) != 0, sz, 8'($urandom % 4 == 0 ? $urandom : 0),
                                     3'($urandom), 1'($urandom), 3'($urandom),
                                     1'($urandom), 1'($urandom), 1'($urandom))});
      if (it % 60 == 59) cfg_write(2'd0, {31'd0, 1'($urandom % 3 != 0)});
      for (int k = 0; k < 4; k++) begin
        logic [31:0] a;
        a = {m_base[4'($urandom)], 5'b0} + ($urandom % 32'h4000);
        probe(a, 1'($urandom), 1'($urandom), 1'($urandom), "R7 random overlap");
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule